// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-ring network controller. A frame arrives as a byte stream with a last-byte marker. When the frame begins, the block walks a ring of 16 descriptors in memory, starting at its own receive pointer. It reads each descriptor's status byte and looks for the first entry that the host has handed to the device. The frame bytes go into that entry's buffer. The length word goes into the descriptor, and the status byte is then rewritten to give the entry back to the host. A one-cycle receive event follows.

Memory access uses a single byte-wide request/acknowledge port. The ring base address, the buffer area base address and a stop flag are plain inputs, which some other block drives. When the controller is stopped, or when no descriptor is free, the frame is consumed and discarded. The free-descriptor case raises a one-cycle missed-frame pulse. Each descriptor holds one whole frame: no chaining across descriptors, no address filtering and no CRC check.

Top module: `rx_ring_writer`

## Requirements
- R1: If `stopped` is high when a frame's first byte is offered, the whole frame is accepted and dropped. There is no memory request and no event pulse.
- R2: Descriptor i begins at `ring_base + 8*i`, and its status byte sits at offset 2. An entry counts as free only when that byte is exactly 0x80. Any other value, 0x81 or 0xC0 included, is skipped.
- R3: The search starts at the receive pointer and wraps modulo 16. It takes the first free entry it finds. It ends before it reaches entry (pointer-1) mod 16, so that entry is never taken.
- R4: Byte k of the frame is written to `buf_base + i*BUF_BYTES + k` (1544 by default). Only the first BUF_BYTES bytes are written; the rest are accepted and not stored.
- R5: The length word is the received byte count plus 4. Its high byte is written at descriptor offset 6 and its low byte at offset 7.
- R6: The status byte is written as 0x03 (owner clear, start and end set). It is the frame's last memory write and is issued only after both length bytes are acknowledged.
- R7: Each taken descriptor advances the receive pointer by exactly one, modulo 16, whichever entry the search actually used.
- R8: `rx_event` pulses for one cycle, the cycle after the status write is acknowledged. There is one pulse per stored frame.
- R9: If no entry is free, there are no memory writes. `rx_miss` pulses once and the frame is drained.
- R10: Reset clears the receive pointer to 0, idles the memory port and clears both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stopped | input | 1 | Controller stopped; frames are discarded |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| buf_base | input | ADDR_W | Byte address of the buffer for descriptor 0 |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Frame byte accepted this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| rx_event | output | 1 | One-cycle pulse per stored frame |
| rx_miss | output | 1 | One-cycle pulse per frame dropped for lack of a descriptor |

## Verification
The assertions assume that memory holds `mem_ack` low unless a request is pending, and returns it for exactly one cycle per access. They also assume that the stream source keeps `s_valid`, `s_data` and `s_last` steady until a byte is taken, and that `stopped` and both base addresses do not change while a frame is in flight. The bench's memory model acks every request one cycle after it appears and never acks twice in a row. The bench drives bytes on the falling edge and holds them until `s_ready` is seen. It changes the stop flag and the ring contents only between frames, once the block has gone idle.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   localparam int LEN_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_DATA,
      ST_LEN0,
      ST_LEN1,
      ST_STAT,
      ST_DRAIN
   } rxw_state_e;

   typedef enum logic [1:0] {
      AS_STAT,
      AS_LEN0,
      AS_LEN1,
      AS_DATA
   } rxw_asel_e;

endpackage

// File: rtl/rxw_ring_ptr.sv
module rxw_ring_ptr #(
   parameter int RING_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_start,
   input  logic                 scan_next,
   input  logic                 take,
   output logic [RING_LOG2-1:0] ptr,
   output logic [RING_LOG2-1:0] idx,
   output logic                 scan_last
);
   localparam logic [RING_LOG2-1:0] ONE = RING_LOG2'(1);

   logic [RING_LOG2-1:0] stop_idx;

   assign stop_idx  = ptr - ONE;
   assign scan_last = (idx + ONE) == stop_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         idx <= '0;
      end else begin
         if (take)
            ptr <= ptr + ONE;
         if (scan_start)
            idx <= ptr;
         else if (scan_next)
            idx <= idx + ONE;
      end
   end

   // R7: the pointer moves only when a descriptor is taken
   assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ptr == $past(ptr));

   // R3: the controller never steps the search onto the entry behind the pointer
   assert_scan_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_next |-> !scan_last);

endmodule

// File: rtl/rxw_addr_gen.sv
module rxw_addr_gen
   import rxw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int RING_LOG2  = 4,
   parameter int DESC_BYTES = 8,
   parameter int BUF_BYTES  = 1544,
   parameter int STAT_OFS   = 2,
   parameter int MLEN_OFS   = 6
) (
   input  logic [ADDR_W-1:0]    ring_base,
   input  logic [ADDR_W-1:0]    buf_base,
   input  logic [RING_LOG2-1:0] idx,
   input  logic [LEN_W-1:0]     cnt,
   input  rxw_asel_e            sel,
   output logic [ADDR_W-1:0]    slot_base,
   output logic [ADDR_W-1:0]    addr
);
   localparam logic [ADDR_W-1:0] DSTEP = ADDR_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] BSTEP = ADDR_W'(BUF_BYTES);
   localparam logic [ADDR_W-1:0] SOFS  = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] MOFS  = ADDR_W'(MLEN_OFS);

   logic [ADDR_W-1:0] desc_base;

   assign desc_base = ring_base + ADDR_W'(idx) * DSTEP;
   assign slot_base = buf_base  + ADDR_W'(idx) * BSTEP;

   always_comb begin
      unique case (sel)
         AS_STAT: addr = desc_base + SOFS;
         AS_LEN0: addr = desc_base + MOFS;
         AS_LEN1: addr = desc_base + MOFS + ADDR_W'(1);
         default: addr = slot_base + ADDR_W'(cnt);
      endcase
   end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxw_pkg::*;
#(
   parameter int       ADDR_W       = 32,
   parameter int       RING_LOG2    = 4,
   parameter int       DESC_BYTES   = 8,
   parameter int       BUF_BYTES    = 1544,
   parameter int       STAT_OFS     = 2,
   parameter int       MLEN_OFS     = 6,
   parameter int       LEN_BIAS     = 4,
   parameter bit       LEN_HI_FIRST = 1'b1,
   parameter bit [7:0] FREE_CODE    = 8'h80,
   parameter bit [7:0] DONE_CODE    = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stopped,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [ADDR_W-1:0] buf_base,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   output logic              rx_event,
   output logic              rx_miss
);
   localparam logic [LEN_W-1:0]  CAP   = LEN_W'(BUF_BYTES);
   localparam logic [LEN_W-1:0]  BIAS  = LEN_W'(LEN_BIAS);
   localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(BUF_BYTES);

   // elaboration-time parameter checks
   if (RING_LOG2 < 2)
      begin : g_bad_ring  $error("RING_LOG2 must be at least 2"); end
   if (STAT_OFS >= DESC_BYTES || MLEN_OFS + 2 > DESC_BYTES)
      begin : g_bad_desc  $error("descriptor fields exceed DESC_BYTES"); end
   if (BUF_BYTES < 1 || BUF_BYTES + LEN_BIAS >= (1 << LEN_W))
      begin : g_bad_buf   $error("BUF_BYTES does not fit the length word"); end

   rxw_state_e           state, state_nx;
   rxw_asel_e            asel;
   logic [LEN_W-1:0]     cnt;
   logic [LEN_W-1:0]     len_word;
   logic [7:0]           len_b0, len_b1;
   logic [RING_LOG2-1:0] ptr, idx;
   logic                 scan_last, scan_start, scan_next, take;
   logic                 in_cap, beat, is_free;
   logic [ADDR_W-1:0]    slot_base;

   assign in_cap   = cnt < CAP;
   assign is_free  = mem_rdata == FREE_CODE;
   assign len_word = cnt + BIAS;

   // the length byte order is a build option
   if (LEN_HI_FIRST) begin : g_len_hi_first
      assign len_b0 = len_word[15:8];
      assign len_b1 = len_word[7:0];
   end else begin : g_len_lo_first
      assign len_b0 = len_word[7:0];
      assign len_b1 = len_word[15:8];
   end

   rxw_ring_ptr #(.RING_LOG2(RING_LOG2)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_start (scan_start),
      .scan_next  (scan_next),
      .take       (take),
      .ptr        (ptr),
      .idx        (idx),
      .scan_last  (scan_last)
   );

   rxw_addr_gen #(
      .ADDR_W     (ADDR_W),
      .RING_LOG2  (RING_LOG2),
      .DESC_BYTES (DESC_BYTES),
      .BUF_BYTES  (BUF_BYTES),
      .STAT_OFS   (STAT_OFS),
      .MLEN_OFS   (MLEN_OFS)
   ) u_addr (
      .ring_base (ring_base),
      .buf_base  (buf_base),
      .idx       (idx),
      .cnt       (cnt),
      .sel       (asel),
      .slot_base (slot_base),
      .addr      (mem_addr)
   );

   always_comb begin
      state_nx   = state;
      asel       = AS_DATA;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_wdata  = s_data;
      s_ready    = 1'b0;
      scan_start = 1'b0;
      scan_next  = 1'b0;
      take       = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (s_valid) begin
               if (stopped) begin
                  state_nx = ST_DRAIN;
               end else begin
                  scan_start = 1'b1;
                  state_nx   = ST_SCAN;
               end
            end
         end
         ST_SCAN: begin
            asel    = AS_STAT;
            mem_req = 1'b1;
            if (mem_ack) begin
               if (is_free) begin
                  take     = 1'b1;
                  state_nx = ST_DATA;
               end else if (scan_last) begin
                  state_nx = ST_DRAIN;
               end else begin
                  scan_next = 1'b1;
               end
            end
         end
         ST_DATA: begin
            asel    = AS_DATA;
            mem_req = s_valid && in_cap;
            mem_we  = 1'b1;
            s_ready = in_cap ? mem_ack : 1'b1;
            if (s_valid && s_ready && s_last)
               state_nx = ST_LEN0;
         end
         ST_LEN0: begin
            asel      = AS_LEN0;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = len_b0;
            if (mem_ack) state_nx = ST_LEN1;
         end
         ST_LEN1: begin
            asel      = AS_LEN1;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = len_b1;
            if (mem_ack) state_nx = ST_STAT;
         end
         ST_STAT: begin
            asel      = AS_STAT;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = DONE_CODE;
            if (mem_ack) state_nx = ST_IDLE;
         end
         ST_DRAIN: begin
            s_ready = 1'b1;
            if (s_valid && s_last) state_nx = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   assign beat = (state == ST_DATA) && s_valid && s_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         rx_event <= 1'b0;
         rx_miss  <= 1'b0;
      end else begin
         state    <= state_nx;
         if (take)
            cnt <= '0;
         else if (beat)
            cnt <= cnt + LEN_W'(1);
         rx_event <= (state == ST_STAT) && mem_ack;
         rx_miss  <= (state == ST_SCAN) && mem_ack && !is_free && scan_last;
      end
   end

   // R1: a frame offered while stopped causes no memory request
   assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && s_valid && stopped) |=> !mem_req);

   // R2: a pending request keeps its address and direction until acknowledged
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R4: frame writes stay inside the chosen descriptor's buffer
   assert_buf_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && mem_req) |-> ((mem_addr - slot_base) < CAP_A));

   // R8: the receive event follows an acknowledged write of the done code
   assert_event_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> ($past(mem_ack) && $past(mem_we) && $past(mem_wdata) == DONE_CODE));

   // R9: draining issues no memory traffic, and the two pulses never coincide
   assert_drain_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN) |-> !mem_req);
   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_event && rx_miss));

endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
   localparam int CLK_PERIOD = 10;
   localparam int BUFB       = 64;
   localparam int RBASE      = 0;
   localparam int BBASE      = 256;
   localparam int NVEC       = 8;

   // vector: {free mask[35:20], frame length[19:8], data seed[7:0]}
   localparam logic [35:0] VEC [NVEC] = '{
      {16'hFFFF, 12'd10, 8'h10},
      {16'h0020, 12'd64, 8'h20},
      {16'h0048, 12'd12, 8'h30},
      {16'h0004, 12'd5,  8'h40},
      {16'h0001, 12'd20, 8'h50},
      {16'h8000, 12'd70, 8'h60},
      {16'h0018, 12'd1,  8'h70},
      {16'hFFFF, 12'd33, 8'h80}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stopped = 1'b0;
   logic        s_valid = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_last = 1'b0;
   logic        s_ready;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        rx_event, rx_miss;

   logic [7:0]  mem [0:2047];
   logic        do_init = 1'b0;
   logic [7:0]  init_stat [16];
   int          wr_cnt = 0, rd_cnt = 0, ev_cnt = 0, miss_cnt = 0, cyc = 0;
   logic [31:0] last_wr = '0;
   int          checks = 0, fails = 0;
   int          e_ptr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_ring_writer #(.BUF_BYTES(BUFB)) u0 (
      .clk(clk), .rst_n(rst_n), .stopped(stopped),
      .ring_base(32'(RBASE)), .buf_base(32'(BBASE)),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .rx_event(rx_event), .rx_miss(rx_miss)
   );

   // memory model: one-cycle ack, never two acks in a row
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (do_init) begin
         for (int a = 0; a < 2048; a++) mem[a] <= (a >= BBASE) ? 8'hEE : 8'h00;
         for (int i = 0; i < 16; i++) mem[RBASE + i*8 + 2] <= init_stat[i];
      end
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[10:0]];
         if (mem_we) begin
            mem[mem_addr[10:0]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            last_wr <= mem_addr;
         end else begin
            rd_cnt <= rd_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
      if (rx_event) ev_cnt   <= ev_cnt + 1;
      if (rx_miss)  miss_cnt <= miss_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input int len, input logic [7:0] seed);
      for (int k = 0; k < len; k++) begin
         s_valid = 1'b1;
         s_data  = seed + 8'(k);
         s_last  = (k == len - 1);
         #1;
         while (!s_ready) begin @(negedge clk); #1; end
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic run_vec(input logic [15:0] mask, input int len,
                          input logic [7:0] seed, input bit stop);
      int  slot, wr0, rd0, ev0, ms0, stored, bad, stop_i;
      bit  found;
      for (int i = 0; i < 16; i++)
         init_stat[i] = mask[i] ? 8'h80 : (i[0] ? 8'h81 : 8'hC0);
      // expected slot from the requirements: R3 search order, R2 exact code
      found  = 1'b0;
      slot   = 0;
      stop_i = (e_ptr + 15) % 16;
      for (int i = e_ptr; i != stop_i; i = (i + 1) % 16)
         if (!found && init_stat[i] == 8'h80) begin found = 1'b1; slot = i; end
      stopped = stop;
      do_init = 1'b1;
      @(negedge clk);
      do_init = 1'b0;
      wr0 = wr_cnt; rd0 = rd_cnt; ev0 = ev_cnt; ms0 = miss_cnt;
      send_frame(len, seed);
      repeat (12) @(negedge clk);
      if (stop) begin
         chk(rd_cnt == rd0 && wr_cnt == wr0, "R1", "memory accesses while stopped",
             rd_cnt - rd0 + wr_cnt - wr0, 0);
         chk(ev_cnt == ev0 && miss_cnt == ms0, "R1", "pulses while stopped",
             ev_cnt - ev0 + miss_cnt - ms0, 0);
         stopped = 1'b0;
         return;
      end
      if (!found) begin
         chk(wr_cnt == wr0, "R9", "writes with no free entry", wr_cnt - wr0, 0);
         chk(miss_cnt == ms0 + 1, "R9", "miss pulses", miss_cnt - ms0, 1);
         chk(ev_cnt == ev0, "R9", "event on dropped frame", ev_cnt - ev0, 0);
         return;
      end
      stored = (len < BUFB) ? len : BUFB;
      chk(mem[RBASE + slot*8 + 2] == 8'h03, "R3 R7", "status of expected slot",
          int'(mem[RBASE + slot*8 + 2]), 3);
      bad = 0;
      for (int i = 0; i < 16; i++)
         if (i != slot && mem[RBASE + i*8 + 2] != init_stat[i]) bad++;
      chk(bad == 0, "R2 R3", "other status bytes changed", bad, 0);
      chk(mem[RBASE + slot*8 + 6] == 8'((len + 4) >> 8), "R5", "length high byte",
          int'(mem[RBASE + slot*8 + 6]), (len + 4) >> 8);
      chk(mem[RBASE + slot*8 + 7] == 8'(len + 4), "R5", "length low byte",
          int'(mem[RBASE + slot*8 + 7]), (len + 4) & 255);
      bad = 0;
      for (int k = 0; k < stored; k++)
         if (mem[BBASE + slot*BUFB + k] != seed + 8'(k)) bad++;
      chk(bad == 0, "R4", "buffer byte mismatches", bad, 0);
      if (len > BUFB)
         chk(mem[BBASE + slot*BUFB + BUFB] == 8'hEE, "R4", "byte past capacity",
             int'(mem[BBASE + slot*BUFB + BUFB]), 238);
      chk(wr_cnt - wr0 == stored + 3, "R4 R6", "write count", wr_cnt - wr0, stored + 3);
      chk(last_wr == 32'(RBASE + slot*8 + 2), "R6", "last write address",
          int'(last_wr), RBASE + slot*8 + 2);
      chk(ev_cnt == ev0 + 1, "R8", "event pulses", ev_cnt - ev0, 1);
      chk(miss_cnt == ms0, "R8", "miss on stored frame", miss_cnt - ms0, 0);
      e_ptr = (e_ptr + 1) % 16;
   endtask

   // watchdog
   initial begin
      wait (cyc > 150000);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !rx_event && !rx_miss && !s_ready, "R10", "idle after reset",
          int'({mem_req, rx_event, rx_miss, s_ready}), 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NVEC; v++)
         run_vec(VEC[v][35:20], int'(VEC[v][19:8]), VEC[v][7:0], 1'b0);

      // directed: stopped frame with every entry free (R1)
      run_vec(16'hFFFF, 9, 8'hA0, 1'b1);
      // pointer unchanged by the stopped frame: next frame takes e_ptr (R1 R7)
      run_vec(16'hFFFF, 4, 8'hB0, 1'b0);

      // directed: reset returns the pointer to entry 0 (R10)
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      e_ptr = 0;
      @(negedge clk);
      run_vec(16'hFFFF, 6, 8'hC0, 1'b0);
      chk(mem[RBASE + 2] == 8'h03, "R10", "entry 0 taken after reset",
          int'(mem[RBASE + 2]), 3);

      // directed: only the entry behind the pointer is free (R3)
      run_vec(16'(1) << ((e_ptr + 15) % 16), 2, 8'hD0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule